// File: doc/BRIEF.md
# Configurable UART Serial Engine

This block is the bit-level core of a memory-mapped serial port. It turns bytes handed over on a transmit holding interface into asynchronous serial frames on `tx_pin`, and it recovers bytes from `rx_pin`, attaching a four-bit error word to each received byte. Frame shape is set by a line-configuration word: data length, parity mode and stop-bit count. Direction enables, an internal loopback path and a forced break level come from a control word. The bit rate comes from a divisor that is programmed as clock/16/baud minus one. Queues, interrupt logic and modem flow control live in a neighbouring block, which consumes `rx_valid`/`rx_data`/`rx_status` and feeds `tx_valid`/`tx_data`.

A divider produces an oversampling tick every `baud_div + 1` clocks. Each serial bit lasts 16 ticks. The transmitter is a state machine with the states TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP. Its transitions are: TX_IDLE to TX_START when a byte is accepted; TX_START to TX_DATA after 16 ticks; TX_DATA to TX_PAR (parity enabled) or to TX_STOP (no parity) once the last data bit has ended; TX_PAR to TX_STOP after one bit time; and TX_STOP to TX_IDLE when the last stop bit has ended.

The receiver is a state machine with the states RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP and RX_RECOVER. Its transitions are: RX_IDLE to RX_START on a tick that sees the line low; RX_START to RX_IDLE when the mid-bit sample is high (a glitch), or to RX_DATA when it is low; RX_DATA to RX_PAR or RX_STOP after the last data sample; RX_PAR to RX_STOP; RX_STOP to RX_IDLE if the stop sample is high, or to RX_RECOVER if it is low; and RX_RECOVER to RX_IDLE once the line is high again.

Top module: `uart_serial_engine`

## Requirements
- R1: An oversampling tick occurs once every `baud_div + 1` clocks, and every serial bit lasts 16 ticks. Because the divider runs freely, the first start bit after an idle period lasts between 15·(baud_div+1)+1 and 16·(baud_div+1) clocks.
- R2: `line_cfg[1:0]` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data is sent least significant bit first after one low start bit. The line idles high. A received byte is zero above its length, and a clean frame reports `rx_status` = 0.
- R3: `line_cfg[5:3]` sets parity: 4 is odd, 5 is even, 6 always sends 1, 7 always sends 0, and any code from 0 to 3 means no parity bit. On a parity mismatch the receiver sets `rx_status[1]`.
- R4: With `line_cfg[2]` set, the transmitter sends two stop bits; with it clear, it sends one. The receiver checks only the first stop bit, so a new start may follow it immediately.
- R5: A stop bit sampled low sets `rx_status[2]` (frame error). If every data, parity and stop sample was low, `rx_status[3]` (break) is set as well and the parity flag is suppressed. After a low stop bit, the receiver waits for a high line before it looks for a new start.
- R6: `ctrl_cfg[5]` (loopback) routes the transmit line into the receiver, holds `tx_pin` high and ignores `rx_pin`. `ctrl_cfg[4]` (break) forces the transmit line low.
- R7: The receiver samples the start bit 8 ticks after it first sees the line low. If the line is high at that sample, it drops the start without delivering a byte.
- R8: `ctrl_cfg[3:2]` is the transmit mode and `ctrl_cfg[1:0]` the receive mode; 0 disables that direction and any other value enables it. With transmit mode 0, `tx_ready` stays low and the line stays idle. With receive mode 0, the line is ignored.
- R9: A received byte is held on `rx_data`/`rx_status` with `rx_valid` high until `rx_ack`. If a new byte completes while the old one is unacknowledged, it replaces the old one and sets `rx_status[0]` (overrun).
- R10: `shifter_empty` falls on the cycle after a byte is accepted and rises again only after the last stop bit has finished.
- R11: After reset, `tx_pin` is high, `shifter_empty` is 1, `rx_valid` is 0, and `tx_ready` is 1 when transmit mode is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Divisor, clock/16/baud minus one |
| line_cfg | input | 6 | Parity [5:3], two stops [2], length [1:0] |
| ctrl_cfg | input | 6 | Loopback [5], break [4], TX mode [3:2], RX mode [1:0] |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter idle and enabled; byte taken when valid |
| shifter_empty | output | 1 | No frame in progress on the transmitter |
| tx_pin | output | 1 | Serial output |
| rx_pin | input | 1 | Serial input |
| rx_valid | output | 1 | Received byte held |
| rx_ack | input | 1 | Consumer has taken the held byte |
| rx_data | output | 8 | Received byte |
| rx_status | output | 4 | Break [3], frame [2], parity [1], overrun [0] |

## Verification
The bench decodes the transmit pin by itself for every combination of length, parity code, stop count and divisor. A transmitter with a reversed bit order, a wrong odd/even sense or a missing second stop would produce a wrong bit at a mid-bit sample. Hand-made frames drive the receiver through a parity mismatch, a low stop, an all-zero break and a short start glitch. A receiver that never suppressed the parity flag on a break, kept a glitch, or re-triggered on the low tail of a bad frame would deliver a wrong status or a phantom byte. Back-to-back frames with only one stop bit, an unacknowledged pair of frames, loopback with `rx_pin` held low, and disabled modes check the re-arm timing, the overrun flag, the isolation of the external pin and the idle behaviour.

// File: rtl/uart_eng_pkg.sv
package uart_eng_pkg;

    localparam int BYTE_W = 8;
    localparam int ERR_W  = 4;

    // Error word bit positions (decoded by the neighbouring block)
    localparam int ERR_OVR = 0;
    localparam int ERR_PAR = 1;
    localparam int ERR_FRM = 2;
    localparam int ERR_BRK = 3;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_RECOVER
    } rx_state_e;

    // Parity bit for a frame; sel[2] clear means no parity (result unused)
    function automatic logic calc_parity(input logic [2:0] sel,
                                         input logic [BYTE_W-1:0] d,
                                         input logic [1:0] len);
        logic [BYTE_W-1:0] mask;
        logic x;
        mask = 8'hFF >> (2'd3 - len);
        x = ^(d & mask);
        unique case (sel)
            3'd4:    calc_parity = ~x;
            3'd5:    calc_parity = x;
            3'd6:    calc_parity = 1'b1;
            3'd7:    calc_parity = 1'b0;
            default: calc_parity = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= div;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    // R1: with a non-zero divisor, ticks never occur on adjacent clocks
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_eng_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        mode,
    input  logic [1:0]        len,
    input  logic [2:0]        par_sel,
    input  logic              two_stop,
    input  logic              valid,
    input  logic [BYTE_W-1:0] data,
    output logic              ready,
    output logic              line,
    output logic              empty
);

    localparam int CNT_W = $clog2(OS_RATE);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OS_RATE - 1);

    tx_state_e         state, nxt;
    logic [CNT_W-1:0]  tcnt;
    logic [2:0]        bidx;
    logic              sidx;
    logic [BYTE_W-1:0] shreg;
    logic [1:0]        len_q;
    logic              par_en_q, par_val_q, two_q;
    logic              accept, bit_end;
    logic [2:0]        last_bit;

    assign accept   = (state == TX_IDLE) && valid && (mode != 2'b00);
    assign bit_end  = tick && (tcnt == LAST_TICK);
    assign last_bit = {1'b0, len_q} + 3'd4;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (accept) nxt = TX_START;
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && bidx == last_bit)
                          nxt = par_en_q ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) nxt = TX_STOP;
            TX_STOP:  if (bit_end && sidx == two_q) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    // Frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            bidx      <= '0;
            sidx      <= 1'b0;
            shreg     <= '0;
            len_q     <= '0;
            par_en_q  <= 1'b0;
            par_val_q <= 1'b0;
            two_q     <= 1'b0;
        end else if (accept) begin
            tcnt      <= '0;
            bidx      <= '0;
            sidx      <= 1'b0;
            shreg     <= data;
            len_q     <= len;
            par_en_q  <= par_sel[2];
            par_val_q <= calc_parity(par_sel, data, len);
            two_q     <= two_stop;
        end else if (tick && state != TX_IDLE) begin
            tcnt <= (tcnt == LAST_TICK) ? '0 : tcnt + 1'b1;
            if (bit_end && state == TX_DATA) bidx <= bidx + 1'b1;
            if (bit_end && state == TX_STOP) sidx <= ~sidx;
        end
    end

    // Outputs
    always_comb begin
        ready = 1'b0;
        empty = 1'b0;
        line  = 1'b1;
        unique case (state)
            TX_IDLE: begin
                ready = (mode != 2'b00);
                empty = 1'b1;
                line  = 1'b1;
            end
            TX_START: line = 1'b0;
            TX_DATA:  line = shreg[bidx];
            TX_PAR:   line = par_val_q;
            TX_STOP:  line = 1'b1;
            default:  line = 1'b1;
        endcase
    end

    // R8: a disabled transmitter never offers to accept
    assert_tx_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> !ready);

    // R10: an accepted byte makes the shifter busy on the next cycle
    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> !empty);

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_eng_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        mode,
    input  logic [1:0]        len,
    input  logic [2:0]        par_sel,
    input  logic              line,
    input  logic              ack,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic [ERR_W-1:0]  rx_status
);

    localparam int CNT_W = $clog2(OS_RATE);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OS_RATE - 1);
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OS_RATE / 2 - 1);

    rx_state_e         state, nxt;
    logic [CNT_W-1:0]  tcnt;
    logic [2:0]        bidx;
    logic [BYTE_W-1:0] data_q;
    logic [1:0]        len_q;
    logic [2:0]        par_sel_q;
    logic              par_s, all_low;
    logic              start_det, mid_hit, bit_end, done;
    logic              brk, frm, perr, ovr;
    logic [2:0]        last_bit;

    assign start_det = (state == RX_IDLE) && tick && (mode != 2'b00) && !line;
    assign mid_hit   = (state == RX_START) && tick && (tcnt == MID_TICK);
    assign bit_end   = tick && (tcnt == LAST_TICK);
    assign done      = (state == RX_STOP) && bit_end;
    assign last_bit  = {1'b0, len_q} + 3'd4;

    assign frm  = !line;
    assign brk  = frm && all_low;
    assign perr = par_sel_q[2] && !brk &&
                  (par_s != calc_parity(par_sel_q, data_q, len_q));
    assign ovr  = rx_valid && !ack;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:    if (start_det) nxt = RX_START;
            RX_START:   if (mid_hit) nxt = line ? RX_IDLE : RX_DATA;
            RX_DATA:    if (bit_end && bidx == last_bit)
                            nxt = par_sel_q[2] ? RX_PAR : RX_STOP;
            RX_PAR:     if (bit_end) nxt = RX_STOP;
            RX_STOP:    if (bit_end) nxt = line ? RX_IDLE : RX_RECOVER;
            RX_RECOVER: if (line) nxt = RX_IDLE;
            default:    nxt = RX_IDLE;
        endcase
    end

    // Sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            bidx      <= '0;
            data_q    <= '0;
            len_q     <= '0;
            par_sel_q <= '0;
            par_s     <= 1'b0;
            all_low   <= 1'b0;
        end else if (start_det) begin
            tcnt      <= '0;
            bidx      <= '0;
            data_q    <= '0;
            len_q     <= len;
            par_sel_q <= par_sel;
            all_low   <= 1'b1;
        end else if (tick) begin
            unique case (state)
                RX_START:
                    tcnt <= mid_hit ? '0 : tcnt + 1'b1;
                RX_DATA: begin
                    tcnt <= bit_end ? '0 : tcnt + 1'b1;
                    if (bit_end) begin
                        data_q[bidx] <= line;
                        bidx         <= bidx + 1'b1;
                        if (line) all_low <= 1'b0;
                    end
                end
                RX_PAR: begin
                    tcnt <= bit_end ? '0 : tcnt + 1'b1;
                    if (bit_end) begin
                        par_s <= line;
                        if (line) all_low <= 1'b0;
                    end
                end
                RX_STOP:
                    tcnt <= bit_end ? '0 : tcnt + 1'b1;
                default: ;
            endcase
        end
    end

    // Held result towards the consumer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid  <= 1'b0;
            rx_data   <= '0;
            rx_status <= '0;
        end else if (done) begin
            rx_valid           <= 1'b1;
            rx_data            <= data_q;
            rx_status[ERR_OVR] <= ovr;
            rx_status[ERR_PAR] <= perr;
            rx_status[ERR_FRM] <= frm;
            rx_status[ERR_BRK] <= brk;
        end else if (ack) begin
            rx_valid <= 1'b0;
        end
    end

    // R7: a start that reads high at mid-bit is abandoned
    assert_glitch_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_hit && line) |=> (state == RX_IDLE));

    // R8: a disabled receiver stays idle
    assert_rx_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && state == RX_IDLE) |=> (state == RX_IDLE));

    // R9: an unacknowledged byte is held unchanged
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ack && !done) |=> (rx_valid && $stable(rx_data) && $stable(rx_status)));

    // R5: a break report always carries the frame flag
    assert_break_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_status[ERR_BRK]) |-> rx_status[ERR_FRM]);

endmodule

// File: rtl/uart_serial_engine.sv
module uart_serial_engine
    import uart_eng_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic [5:0]       line_cfg,
    input  logic [5:0]       ctrl_cfg,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             shifter_empty,
    output logic             tx_pin,
    input  logic             rx_pin,
    output logic             rx_valid,
    input  logic             rx_ack,
    output logic [7:0]       rx_data,
    output logic [3:0]       rx_status
);

    logic                   tick;
    logic                   tx_line, tx_int, rx_src;
    logic [SYNC_STAGES-1:0] sync_q;

    wire       loop_en  = ctrl_cfg[5];
    wire       brk_en   = ctrl_cfg[4];
    wire [1:0] tx_mode  = ctrl_cfg[3:2];
    wire [1:0] rx_mode  = ctrl_cfg[1:0];
    wire [1:0] len      = line_cfg[1:0];
    wire       two_stop = line_cfg[2];
    wire [2:0] par_sel  = line_cfg[5:3];

    uart_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (baud_div),
        .tick (tick)
    );

    uart_tx_fsm #(.OS_RATE(OS_RATE)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mode    (tx_mode),
        .len     (len),
        .par_sel (par_sel),
        .two_stop(two_stop),
        .valid   (tx_valid),
        .data    (tx_data),
        .ready   (tx_ready),
        .line    (tx_line),
        .empty   (shifter_empty)
    );

    assign tx_int = brk_en ? 1'b0 : tx_line;
    assign tx_pin = loop_en ? 1'b1 : tx_int;
    assign rx_src = loop_en ? tx_int : rx_pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_src};
    end

    uart_rx_fsm #(.OS_RATE(OS_RATE)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (rx_mode),
        .len      (len),
        .par_sel  (par_sel),
        .line     (sync_q[SYNC_STAGES-1]),
        .ack      (rx_ack),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_status(rx_status)
    );

endmodule

// File: tb/uart_serial_engine_bench.sv
`timescale 1ns/1ps
module uart_serial_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd1;
    logic [5:0]  line_cfg = 6'b000_0_11;
    logic [5:0]  ctrl_cfg = 6'b00_01_01;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_ready, shifter_empty, tx_pin;
    logic        rx_valid, rx_ack = 1'b0;
    logic [7:0]  rx_data;
    logic [3:0]  rx_status;
    logic        use_raw = 1'b0, rx_drv = 1'b1;
    logic        rx_pin;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign rx_pin = use_raw ? rx_drv : tx_pin;

    uart_serial_engine u_uart_serial_engine (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .line_cfg(line_cfg),
        .ctrl_cfg(ctrl_cfg), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .shifter_empty(shifter_empty), .tx_pin(tx_pin),
        .rx_pin(rx_pin), .rx_valid(rx_valid), .rx_ack(rx_ack),
        .rx_data(rx_data), .rx_status(rx_status)
    );

    // {div[3:0], parity[2:0], two_stop, len[1:0], data[7:0]}
    localparam logic [17:0] VEC [8] = '{
        {4'd1, 3'd0, 1'b0, 2'd3, 8'hA5},
        {4'd1, 3'd4, 1'b1, 2'd0, 8'h16},
        {4'd3, 3'd5, 1'b0, 2'd1, 8'h2D},
        {4'd1, 3'd6, 1'b1, 2'd2, 8'h7F},
        {4'd1, 3'd7, 1'b0, 2'd3, 8'hC3},
        {4'd2, 3'd5, 1'b1, 2'd3, 8'h01},
        {4'd1, 3'd4, 1'b0, 2'd3, 8'h00},
        {4'd1, 3'd2, 1'b0, 2'd2, 8'hD5}
    };

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic ref_par(input logic [2:0] sel, input logic [7:0] d, input int nb);
        logic x = 1'b0;
        for (int i = 0; i < nb; i++) x ^= d[i];
        case (sel)
            3'd4: return ~x;
            3'd5: return x;
            3'd6: return 1'b1;
            3'd7: return 1'b0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic sample;
        @(posedge clk); #1;
    endtask

    task automatic wait_rx(output bit got);
        got = 0;
        for (int i = 0; i < 3000; i++) begin
            if (rx_valid) begin got = 1; break; end
            sample();
        end
    endtask

    task automatic do_ack;
        @(negedge clk); rx_ack = 1'b1;
        @(negedge clk); rx_ack = 1'b0;
    endtask

    // Offer one byte and wait for the start edge on tx_pin
    task automatic launch(input logic [7:0] d, output bit seen);
        int to = 0;
        @(negedge clk); tx_data = d; tx_valid = 1'b1;
        do begin sample(); to++; end while (tx_pin !== 1'b0 && to < 3000);
        tx_valid = 1'b0;
        seen = (to < 3000);
    endtask

    task automatic raw_frame(input int T, input logic [7:0] d, input int nb,
                             input bit hp, input bit pv, input bit sv, input int idle);
        @(negedge clk); rx_drv = 1'b0;
        repeat (16*T) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_drv = d[i];
            repeat (16*T) @(negedge clk);
        end
        if (hp) begin rx_drv = pv; repeat (16*T) @(negedge clk); end
        rx_drv = sv;
        repeat (16*T) @(negedge clk);
        rx_drv = 1'b1;
        repeat (16*T*idle) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        report();
    end

    initial begin
        bit got;
        // R11: reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) sample();
        chk(tx_pin == 1'b1, "R11 tx_pin", tx_pin, 1);
        chk(shifter_empty == 1'b1, "R11 empty", shifter_empty, 1);
        chk(rx_valid == 1'b0, "R11 rx_valid", rx_valid, 0);
        chk(tx_ready == 1'b1, "R11 tx_ready", tx_ready, 1);

        // Table walk: R2 R3 R4 R10, independent decode of tx_pin, rx sees tx_pin
        for (int v = 0; v < 8; v++) begin
            logic [17:0] e;
            int T, nb;
            logic [7:0] d, got_d, mask;
            logic pexp;
            e = VEC[v];
            T = int'(e[17:14]) + 1;
            nb = int'(e[9:8]) + 5;
            d = e[7:0];
            mask = 8'hFF >> (8 - nb);
            pexp = ref_par(e[13:11], d, nb);
            @(negedge clk);
            baud_div = 16'(e[17:14]);
            line_cfg = {e[13:11], e[10], e[9:8]};
            launch(d, got);
            chk(got, "R10 start seen", got, 1);
            repeat (8*T - 1) sample();
            chk(tx_pin == 1'b0, "R2 start bit", tx_pin, 0);
            chk(shifter_empty == 1'b0, "R10 busy", shifter_empty, 0);
            got_d = 8'h00;
            for (int i = 0; i < nb; i++) begin
                repeat (16*T) sample();
                got_d[i] = tx_pin;
            end
            chk(got_d == (d & mask), "R2 data bits", got_d, d & mask);
            if (e[13]) begin
                repeat (16*T) sample();
                chk(tx_pin == pexp, "R3 parity bit", tx_pin, pexp);
            end
            repeat (16*T) sample();
            chk(tx_pin == 1'b1, "R4 stop one", tx_pin, 1);
            if (e[10]) begin
                repeat (16*T) sample();
                chk(tx_pin == 1'b1, "R4 stop two", tx_pin, 1);
                chk(shifter_empty == 1'b0, "R4 busy in second stop", shifter_empty, 0);
            end
            repeat (8*T + 2) sample();
            chk(shifter_empty == 1'b1, "R10 empty after stop", shifter_empty, 1);
            wait_rx(got);
            chk(got && rx_data == (d & mask), "R2 rx data", rx_data, d & mask);
            chk(rx_status == 4'h0, "R3 rx status clean", rx_status, 0);
            do_ack();
            sample();
            chk(rx_valid == 1'b0, "R9 cleared by ack", rx_valid, 0);
        end

        // R1: first start bit length with divisor 3 (T=4): 61..64 clocks
        begin
            int lows = 0;
            @(negedge clk); baud_div = 16'd3; line_cfg = 6'b000_0_11;
            repeat (40) @(negedge clk);
            launch(8'h01, got);
            lows = 1;
            while (tx_pin == 1'b0 && lows < 200) begin sample(); if (tx_pin == 1'b0) lows++; end
            chk(lows >= 61 && lows <= 64, "R1 start length", lows, 64);
            wait_rx(got);
            chk(got && rx_data == 8'h01, "R1 rx at div 3", rx_data, 8'h01);
            do_ack();
            @(negedge clk); baud_div = 16'd1;
            repeat (40) @(negedge clk);
        end

        use_raw = 1'b1; rx_drv = 1'b1;
        repeat (40) @(negedge clk);

        // R3: parity mismatch, even parity, 0x5A wants 0, send 1
        line_cfg = 6'b101_0_11;
        raw_frame(2, 8'h5A, 8, 1, 1'b1, 1'b1, 2);
        wait_rx(got);
        chk(got && rx_status == 4'b0010, "R3 parity error", rx_status, 4'b0010);
        do_ack();

        // R5: frame error, stop low
        line_cfg = 6'b000_0_11;
        raw_frame(2, 8'h33, 8, 0, 1'b0, 1'b0, 2);
        wait_rx(got);
        chk(got && rx_status == 4'b0100, "R5 frame error", rx_status, 4'b0100);
        chk(rx_data == 8'h33, "R5 frame data", rx_data, 8'h33);
        do_ack();

        // R5: break, odd parity, all low; parity flag suppressed
        line_cfg = 6'b100_0_11;
        raw_frame(2, 8'h00, 8, 1, 1'b0, 1'b0, 3);
        wait_rx(got);
        chk(got && rx_status == 4'b1100, "R5 break", rx_status, 4'b1100);
        do_ack();
        repeat (200) sample();
        chk(rx_valid == 1'b0, "R5 no phantom after break", rx_valid, 0);

        // R7: short start glitch is dropped
        line_cfg = 6'b000_0_11;
        @(negedge clk); rx_drv = 1'b0;
        repeat (6) @(negedge clk);
        rx_drv = 1'b1;
        repeat (400) sample();
        chk(rx_valid == 1'b0, "R7 glitch dropped", rx_valid, 0);

        // R4: two stops configured, receiver re-arms after one stop
        line_cfg = 6'b000_1_11;
        fork
            begin
                raw_frame(2, 8'h3C, 8, 0, 1'b0, 1'b1, 0);
                raw_frame(2, 8'hC3, 8, 0, 1'b0, 1'b1, 2);
            end
            begin
                bit g1, g2;
                wait_rx(g1);
                chk(g1 && rx_data == 8'h3C && rx_status == 4'h0, "R4 rx first", rx_data, 8'h3C);
                do_ack();
                wait_rx(g2);
                chk(g2 && rx_data == 8'hC3 && rx_status == 4'h0, "R4 rx back to back", rx_data, 8'hC3);
                do_ack();
            end
        join

        // R9: overrun when unacknowledged
        line_cfg = 6'b000_0_11;
        raw_frame(2, 8'h11, 8, 0, 1'b0, 1'b1, 1);
        raw_frame(2, 8'h22, 8, 0, 1'b0, 1'b1, 1);
        chk(rx_valid && rx_data == 8'h22, "R9 newest kept", rx_data, 8'h22);
        chk(rx_status == 4'b0001, "R9 overrun flag", rx_status, 4'b0001);
        do_ack();

        // R6: loopback ignores rx_pin (held low) and keeps tx_pin high
        begin
            int lows = 0;
            @(negedge clk); ctrl_cfg = 6'b10_01_01; rx_drv = 1'b0;
            @(negedge clk); tx_data = 8'h96; tx_valid = 1'b1;
            @(negedge clk); tx_valid = 1'b0;
            for (int i = 0; i < 16*2*12; i++) begin
                sample();
                if (tx_pin == 1'b0) lows++;
            end
            chk(lows == 0, "R6 tx_pin idle in loopback", lows, 0);
            wait_rx(got);
            chk(got && rx_data == 8'h96 && rx_status == 4'h0, "R6 loopback data", rx_data, 8'h96);
            do_ack();
            @(negedge clk); rx_drv = 1'b1;
            repeat (10) @(negedge clk);
            ctrl_cfg = 6'b00_01_01;
        end

        // R6: forced break
        @(negedge clk); ctrl_cfg = 6'b01_01_01;
        sample();
        chk(tx_pin == 1'b0, "R6 break low", tx_pin, 0);
        @(negedge clk); ctrl_cfg = 6'b00_01_01;
        sample();
        chk(tx_pin == 1'b1, "R6 break released", tx_pin, 1);

        // R8: transmit disabled
        begin
            int lows = 0;
            @(negedge clk); ctrl_cfg = 6'b00_00_01;
            sample();
            chk(tx_ready == 1'b0, "R8 tx_ready off", tx_ready, 0);
            @(negedge clk); tx_data = 8'h00; tx_valid = 1'b1;
            for (int i = 0; i < 200; i++) begin
                sample();
                if (tx_pin == 1'b0 || shifter_empty == 1'b0) lows++;
            end
            @(negedge clk); tx_valid = 1'b0;
            chk(lows == 0, "R8 tx stays idle", lows, 0);
        end

        // R8: receive disabled, then DMA-coded mode works
        @(negedge clk); ctrl_cfg = 6'b00_01_00;
        raw_frame(2, 8'h5A, 8, 0, 1'b0, 1'b1, 2);
        chk(rx_valid == 1'b0, "R8 rx ignores line", rx_valid, 0);
        @(negedge clk); ctrl_cfg = 6'b00_01_10;
        raw_frame(2, 8'hE7, 8, 0, 1'b0, 1'b1, 2);
        chk(rx_valid && rx_data == 8'hE7, "R8 rx mode 2", rx_data, 8'hE7);
        do_ack();

        report();
    end

endmodule